// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

This block accepts 32-bit words from an external serial master. The master drives three wires: a bit clock, an active-low frame sync and a serial data line. The block samples all three with a faster on-chip system clock. Each wire passes through a synchronizer chain. A falling edge of the bit clock is then found by comparing two successive synchronized samples. Frame sync and data are read only at those falling edges. The external clock alone sets the bit rate, which may be as high as 16 MHz. The system clock must run at four times the highest bit rate or faster.

A frame starts on the first falling edge at which frame sync is seen low after it was seen high. The length of the low pulse has no effect. A two-bit delay setting selects how many bit clocks pass before the most significant data bit arrives. After the 32 bits, one more falling edge is needed before the word is committed to the output register. A new frame may start on that same edge. After reset, the first frame start only arms the receiver, and that frame's data is dropped. If a frame start arrives while a word is only partly received, the partial word is abandoned and reception restarts.

Top module: `fsync_word_rx`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `word_o` is zero and `word_vld_o` and `resync_err_o` are low.
- R2: The first frame start after reset produces no output strobe. Its data is discarded.
- R3: Data bits are sampled on falling edges of `bclk_i`, most significant bit first. After 32 bits, `word_o` holds the word in that order, with the first sampled bit at bit 31.
- R4: With `dly_i` = 0, bit 31 is sampled on the same falling edge that detects the frame start.
- R5: With `dly_i` = 1, bit 31 is sampled on the falling edge after the frame start edge. This is the usual setting.
- R6: With `dly_i` = 2, bit 31 is sampled on the second falling edge after the frame start edge. Code 3 behaves the same as 2.
- R7: A word is committed only on one further falling edge after its bit 0. With no such edge, no strobe appears.
- R8: A frame start on the trailing edge commits the previous word and begins the next frame on that same edge. Back-to-back words are both delivered in order.
- R9: A frame is started only by a high-to-low change of the sampled frame sync. Holding it low for the whole frame gives the same word as a one-bit pulse.
- R10: A frame start seen during the delay or data phase drops the partial word and raises `resync_err_o` for one cycle. Reception restarts with the new frame, and no commit coincides with the error.
- R11: `word_vld_o` is high for exactly one system-clock cycle per commit. `word_o` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit rate |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock (asynchronous) |
| fs_n_i | input | 1 | External frame sync, active low (asynchronous) |
| sd_i | input | 1 | External serial data (asynchronous) |
| dly_i | input | 2 | Data delay in bit clocks: 0, 1, 2 (3 acts as 2) |
| word_o | output | WORD_W | Last committed word |
| word_vld_o | output | 1 | One-cycle strobe when `word_o` is updated |
| resync_err_o | output | 1 | One-cycle pulse when a frame start cuts a word short |

## Verification
The hardest situation to reach is a frame start that lands exactly on the trailing edge. On that one falling edge, the previous word must commit and the next frame must start, capturing bit 31 at once when the delay is zero. The bench reaches it by generating the next frame's first bit period as the trailing period of the previous word. It also reaches a trailing edge that never comes, by parking the bit clock low after bit 0 and watching that no strobe appears until one more bit clock is supplied.

// File: rtl/fswr_pkg.sv
package fswr_pkg;

    // Sequencer phases of one frame
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_BITS = 2'd2,
        ST_TAIL = 2'd3
    } rx_state_e;

    // External pins packed as one vector for the synchronizer bank
    typedef struct packed {
        logic bclk;
        logic fs_n;
        logic sd;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // Pin levels held during reset: clock low, sync idle high, data low
    localparam pins_t PIN_IDLE = '{bclk: 1'b0, fs_n: 1'b1, sd: 1'b0};

    // Code 3 is treated as the longest legal delay
    function automatic logic [1:0] clamp_delay(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/fswr_sync.sv
module fswr_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk_i) begin
            if (rst_i) chain <= {STAGES{RST_VAL[b]}};
            else       chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/fswr_edge.sv
module fswr_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/fswr_frame.sv
module fswr_frame
    import fswr_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fall_i,
    input  logic              fs_n_i,
    input  logic              sd_i,
    input  logic [1:0]        dly_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    rx_state_e         state_q;
    logic              fs_last_q;
    logic              armed_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              start_det;

    // A frame begins only where the sampled sync goes from high to low
    assign start_det = fall_i && fs_last_q && !fs_n_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= ST_IDLE;
            fs_last_q <= 1'b1;
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            shreg_q   <= '0;
            word_o    <= '0;
            vld_o     <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            err_o <= 1'b0;
            if (fall_i) begin
                fs_last_q <= fs_n_i;
                // Trailing edge: commit, possibly alongside a new start
                if (state_q == ST_TAIL) begin
                    word_o  <= shreg_q;
                    vld_o   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                if (start_det) begin
                    if (!armed_q) begin
                        armed_q <= 1'b1;
                    end else begin
                        if (state_q == ST_LEAD || state_q == ST_BITS)
                            err_o <= 1'b1;
                        case (clamp_delay(dly_i))
                            2'd0: begin
                                shreg_q <= {{(WORD_W-1){1'b0}}, sd_i};
                                cnt_q   <= CNT_W'(1);
                                state_q <= ST_BITS;
                            end
                            2'd1: begin
                                cnt_q   <= '0;
                                state_q <= ST_BITS;
                            end
                            default: begin
                                cnt_q   <= '0;
                                state_q <= ST_LEAD;
                            end
                        endcase
                    end
                end else begin
                    case (state_q)
                        ST_LEAD: state_q <= ST_BITS;
                        ST_BITS: begin
                            shreg_q <= {shreg_q[WORD_W-2:0], sd_i};
                            cnt_q   <= cnt_q + CNT_W'(1);
                            if (cnt_q == LAST_CNT) state_q <= ST_TAIL;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/fsync_word_rx.sv
module fsync_word_rx
    import fswr_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bclk_i,
    input  logic              fs_n_i,
    input  logic              sd_i,
    input  logic [1:0]        dly_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              resync_err_o
);

    pins_t raw_pins;
    pins_t sync_pins;
    logic  bclk_fall;

    assign raw_pins = '{bclk: bclk_i, fs_n: fs_n_i, sd: sd_i};

    fswr_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (raw_pins),
        .q_o  (sync_pins)
    );

    fswr_edge u_edge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .lvl_i (sync_pins.bclk),
        .fall_o(bclk_fall)
    );

    fswr_frame #(
        .WORD_W(WORD_W)
    ) u_frame (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .fall_i(bclk_fall),
        .fs_n_i(sync_pins.fs_n),
        .sd_i  (sync_pins.sd),
        .dly_i (dly_i),
        .word_o(word_o),
        .vld_o (word_vld_o),
        .err_o (resync_err_o)
    );

endmodule

// File: rtl/fswr_checker.sv
module fswr_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bclk_fall,
    input logic [WORD_W-1:0] word,
    input logic              vld,
    input logic              err
);

    // R1: outputs are cleared right after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word == '0 && !vld && !err));

    // R7: a commit follows a detected falling edge of the bit clock
    p_commit_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(bclk_fall));

    // R11: strobe is a single cycle
    p_vld_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R11: word only moves together with the strobe
    p_word_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !vld |-> $stable(word));

    // R10: error is a single-cycle pulse
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    // R10: an abandoned word never commits in the same cycle
    p_err_no_commit_r10: assert property (@(posedge clk) disable iff (rst)
        !(err && vld));

endmodule

bind fsync_word_rx fswr_checker #(.WORD_W(WORD_W)) u_fswr_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .bclk_fall(bclk_fall),
    .word     (word_o),
    .vld      (word_vld_o),
    .err      (resync_err_o)
);

// File: tb/fsync_word_rx_bench.sv
`timescale 1ns/1ps
module fsync_word_rx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fs_n = 1'b1;
    logic        sd = 1'b0;
    logic [1:0]  dly = 2'd1;
    logic [31:0] word_o;
    logic        word_vld_o;
    logic        resync_err_o;

    int n_chk = 0;
    int n_fail = 0;
    int vld_cnt = 0;
    int err_cnt = 0;
    int dbl_cnt = 0;
    bit last_vld = 1'b0;
    string cur_req = "R3";
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    fsync_word_rx u_fsync_word_rx (
        .clk_i       (clk),
        .rst_i       (rst),
        .bclk_i      (bclk),
        .fs_n_i      (fs_n),
        .sd_i        (sd),
        .dly_i       (dly),
        .word_o      (word_o),
        .word_vld_o  (word_vld_o),
        .resync_err_o(resync_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One bit period: drive on the rising half, 8 system cycles per half
    task automatic send_bit(input logic f, input logic d);
        @(negedge clk);
        bclk = 1'b1;
        fs_n = f;
        sd   = d;
        repeat (8) @(negedge clk);
        bclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] w, input int lead,
                              input int fs_len, input int nbits);
        for (int p = 0; p < lead + nbits; p++)
            send_bit((p < fs_len) ? 1'b0 : 1'b1,
                     (p >= lead) ? w[31 - (p - lead)] : 1'b0);
    endtask

    task automatic idle_bit();
        send_bit(1'b1, 1'b0);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (word_vld_o) begin
                    vld_cnt++;
                    if (last_vld) dbl_cnt++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected word", word_o, 32'h0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(word_o == e, cur_req, "received word", word_o, e);
                    end
                end
                if (resync_err_o) err_cnt++;
                last_vld = word_vld_o;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int v0;
        int e0;
        repeat (10) @(negedge clk);
        // R1: reset state
        check(word_o == 32'h0, "R1", "word in reset", word_o, 32'h0);
        check({30'b0, word_vld_o, resync_err_o} == 32'h0, "R1", "strobes in reset",
              {30'b0, word_vld_o, resync_err_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(word_o == 32'h0, "R1", "word after release", word_o, 32'h0);

        // R2: first frame start only arms
        cur_req = "R2";
        send_frame(32'hDEAD_BEEF, 1, 1, 32);
        idle_bit();
        repeat (20) @(negedge clk);
        check(vld_cnt == 0, "R2", "strobes for first frame", vld_cnt, 0);

        // R3 / R5: delay 1, two patterns
        cur_req = "R5";
        exp_q.push_back(32'h1234_5678);
        send_frame(32'h1234_5678, 1, 1, 32);
        idle_bit();
        cur_req = "R3";
        exp_q.push_back(32'hA5A5_0F0F);
        send_frame(32'hA5A5_0F0F, 1, 1, 32);
        idle_bit();

        // R4 / R8: delay 0 back to back
        dly = 2'd0;
        cur_req = "R4";
        exp_q.push_back(32'h8000_0001);
        send_frame(32'h8000_0001, 0, 1, 32);
        cur_req = "R8";
        exp_q.push_back(32'h7FFF_FFFE);
        send_frame(32'h7FFF_FFFE, 0, 1, 32);
        idle_bit();

        // R8: delay 1 back to back
        dly = 2'd1;
        exp_q.push_back(32'hC3C3_3C3C);
        send_frame(32'hC3C3_3C3C, 1, 1, 32);
        exp_q.push_back(32'h0102_0408);
        send_frame(32'h0102_0408, 1, 1, 32);
        idle_bit();

        // R6: delay 2 and code 3
        dly = 2'd2;
        cur_req = "R6";
        exp_q.push_back(32'hF00D_CAFE);
        send_frame(32'hF00D_CAFE, 2, 1, 32);
        idle_bit();
        dly = 2'd3;
        exp_q.push_back(32'h5555_AAAA);
        send_frame(32'h5555_AAAA, 2, 1, 32);
        idle_bit();

        // R7: no trailing edge, no commit
        dly = 2'd1;
        cur_req = "R7";
        repeat (20) @(negedge clk);
        v0 = vld_cnt;
        exp_q.push_back(32'h0BAD_F00D);
        send_frame(32'h0BAD_F00D, 1, 1, 32);
        repeat (100) @(negedge clk);
        check(vld_cnt == v0, "R7", "strobes before trailing edge", vld_cnt, v0);
        idle_bit();
        repeat (20) @(negedge clk);
        check(vld_cnt == v0 + 1, "R7", "strobes after trailing edge", vld_cnt, v0 + 1);

        // R9: sync held low for the whole frame
        cur_req = "R9";
        exp_q.push_back(32'h9ABC_DEF0);
        send_frame(32'h9ABC_DEF0, 1, 33, 32);
        idle_bit();

        // R10: restart in the middle of a word
        cur_req = "R10";
        e0 = err_cnt;
        v0 = vld_cnt;
        send_frame(32'hFFFF_FFFF, 1, 1, 10);
        exp_q.push_back(32'h2468_ACE1);
        send_frame(32'h2468_ACE1, 1, 1, 32);
        idle_bit();
        repeat (20) @(negedge clk);
        check(err_cnt == e0 + 1, "R10", "error pulses", err_cnt, e0 + 1);
        check(vld_cnt == v0 + 1, "R10", "words after restart", vld_cnt, v0 + 1);

        // R11 and end of scoreboard
        check(dbl_cnt == 0, "R11", "multi-cycle strobes", dbl_cnt, 0);
        check(exp_q.size() == 0, "R8", "words still expected", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule